// File: doc/BRIEF.md
# ADC result register with read lock

This block is the digital control and result logic that sits between a CPU bus and an analog-to-digital converter core. Software starts a conversion by writing a start bit. A timer compare match can also start one, with no CPU write, when auto-trigger is enabled. An internal sequencer holds the conversion busy for a fixed number of clock ticks. It sends the core a one-cycle start strobe and captures the settled sample from the core in the tick where the conversion finishes.

The completed sample is kept in a result register that the CPU reads as two bytes, low and high. Each read formats the sample right-adjusted or left-adjusted. In left-adjusted mode, a read of the high byte alone gives an 8-bit result.

Reading the low byte locks the result register, so the following high-byte read belongs to the same conversion. A conversion that finishes while the lock is held is dropped. Every completion raises an interrupt flag, and the flag is already set in the same cycle that the register shows the new sample.

Top module: `adc_result_ctl`

## Requirements
- R1: After reset, the low byte (address 0), high byte (address 1) and control byte (address 2) all read 0, and `irq` and `conv_start` are 0.
- R2: Writing address 2 with bit 0 set starts a conversion. `conv_start` pulses for one cycle, and control bit 0 reads 1 for exactly 13 cycles after the write edge, then clears by itself.
- R3: A start write or a timer trigger that arrives while a conversion is busy is ignored. Completion still occurs 13 cycles after the original start, and no extra `conv_start` pulse is issued.
- R4: The result register changes only in the completion cycle. While a conversion runs, reads return the previous completed sample.
- R5: A read of address 0 locks the result register. A completion in the same cycle as that read, or in any later cycle while the lock is held, leaves both bytes unchanged and the sample is lost.
- R6: A read of address 1 releases the lock. A completion in the same cycle as that read updates the register.
- R7: With control bit 2 at 0 (right-adjusted), the low byte is sample[7:0] and the high byte is {000000, sample[9:8]}.
- R8: With control bit 2 at 1 (left-adjusted), the high byte is sample[9:2] and the low byte is {sample[1:0], 000000}. The setting applies at read time to the stored sample.
- R9: With control bit 1 at 1, a `tmr_cmp_match` pulse starts a conversion exactly as a start write does. With control bit 1 at 0, the pulse has no effect.
- R10: Control bit 3 (the interrupt flag, driven on `irq`) sets on every completion, including a completion whose sample was dropped because of the lock.
- R11: The flag clears on `irq_ack` or on a write of 1 to control bit 3. A completion in the same cycle as a clear leaves the flag set.
- R12: In the first cycle in which `irq` reads 1 after a completion, the result bytes already hold that completed sample (unless it was dropped).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (reads of addresses 0 and 1 move the lock) |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed byte |
| tmr_cmp_match | input | 1 | Timer compare-match pulse used as an auto-trigger |
| conv_start | output | 1 | One-cycle start strobe to the converter core |
| conv_sample | input | 10 | Settled sample from the converter core |
| irq | output | 1 | Conversion-complete interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge; clears the flag |

## Verification
The lock is the state most likely to go wrong unseen, so the bench drives completions in the same cycle as a low-byte read and in the same cycle as a high-byte read. The next pair of byte reads then shows whether the stored sample moved. A miscounted sequencer shows within one cycle at the conversion boundary, because the start bit is read in the 13th and 14th cycles after launch. A flag that drops a set, or lets a clear win, shows on `irq` in the cycle after the collision.

// File: rtl/adcres_pkg.sv
package adcres_pkg;

   // Register select derived from the byte address
   typedef enum logic [1:0] {
      SEL_LO   = 2'd0,
      SEL_HI   = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // Control byte field positions
   localparam int unsigned CTL_START  = 0;
   localparam int unsigned CTL_AUTO   = 1;
   localparam int unsigned CTL_LADJ   = 2;
   localparam int unsigned CTL_FLAG   = 3;
   localparam int unsigned CTL_FIELDS = 4;

endpackage

// File: rtl/adcres_seq.sv
// Conversion sequencer: busy window of CONV_CYCLES ticks, start strobe out
module adcres_seq #(
   parameter int unsigned CONV_CYCLES = 13
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_req,
   output logic busy,
   output logic start_pulse,
   output logic done
);
   localparam int unsigned CW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;

   generate
      if (CONV_CYCLES < 2) begin : g_bad_len
         $error("adcres_seq: CONV_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] remain_q;

   assign done = busy && (remain_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy        <= 1'b0;
         remain_q    <= '0;
         start_pulse <= 1'b0;
      end else begin
         start_pulse <= 1'b0;
         if (busy) begin
            if (remain_q == '0) begin
               busy <= 1'b0;
            end else begin
               remain_q <= remain_q - 1'b1;
            end
         end else if (go_req) begin
            busy        <= 1'b1;
            remain_q    <= CW'(CONV_CYCLES - 1);
            start_pulse <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/adcres_hold.sv
// Result holding register with read lock
module adcres_hold #(
   parameter int unsigned SAMPLE_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                done,
   input  logic [SAMPLE_W-1:0] sample_in,
   input  logic                rd_lo,
   input  logic                rd_hi,
   output logic [SAMPLE_W-1:0] res_q,
   output logic                lock_q
);
   logic blocked;

   // A low read in the completion cycle already returned the old byte,
   // so it blocks; a high read in that cycle has consumed its byte, so it releases.
   assign blocked = (lock_q && !rd_hi) || rd_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q  <= '0;
         lock_q <= 1'b0;
      end else begin
         if (done && !blocked) begin
            res_q <= sample_in;
         end
         if (rd_lo) begin
            lock_q <= 1'b1;
         end else if (rd_hi) begin
            lock_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/adcres_fmt.sv
// Byte-pair formatter: right- or left-adjusted view of the stored sample
module adcres_fmt #(
   parameter int unsigned SAMPLE_W = 10,
   parameter int unsigned BYTE_W   = 8
) (
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                left_adj,
   output logic [BYTE_W-1:0]   lo_byte,
   output logic [BYTE_W-1:0]   hi_byte
);
   localparam int unsigned PAIR_W = 2 * BYTE_W;
   localparam int unsigned PAD_W  = PAIR_W - SAMPLE_W;

   logic [PAIR_W-1:0] right_view;
   logic [PAIR_W-1:0] left_view;
   logic [PAIR_W-1:0] pair;

   generate
      if (PAD_W == 0) begin : g_full
         assign right_view = sample;
         assign left_view  = sample;
      end else begin : g_padded
         assign right_view = {{PAD_W{1'b0}}, sample};
         assign left_view  = {sample, {PAD_W{1'b0}}};
      end
   endgenerate

   assign pair    = left_adj ? left_view : right_view;
   assign lo_byte = pair[BYTE_W-1:0];
   assign hi_byte = pair[PAIR_W-1:BYTE_W];
endmodule

// File: rtl/adcres_flag.sv
// Completion flag: set wins over clear
module adcres_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_result_ctl.sv
module adc_result_ctl
   import adcres_pkg::*;
#(
   parameter int unsigned SAMPLE_W    = 10,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned CONV_CYCLES = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [BYTE_W-1:0]   bus_wdata,
   output logic [BYTE_W-1:0]   bus_rdata,
   input  logic                tmr_cmp_match,
   output logic                conv_start,
   input  logic [SAMPLE_W-1:0] conv_sample,
   output logic                irq,
   input  logic                irq_ack
);
   generate
      if (SAMPLE_W <= BYTE_W || SAMPLE_W > 2 * BYTE_W) begin : g_bad_width
         $error("adc_result_ctl: SAMPLE_W must lie in (BYTE_W, 2*BYTE_W]");
      end
      if (BYTE_W < CTL_FIELDS) begin : g_bad_byte
         $error("adc_result_ctl: BYTE_W too narrow for control fields");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("adc_result_ctl: ADDR_W must be at least 2");
      end
   endgenerate

   reg_sel_e sel;
   logic     auto_en_q, left_adj_q;
   logic     busy, done, flag_q;
   logic     rd_lo, rd_hi, wr_ctl, go_req, flag_clr;
   logic [SAMPLE_W-1:0] res_q;
   logic                lock_q;
   logic [BYTE_W-1:0]   lo_byte, hi_byte, ctl_byte;
   logic                unused_wdata;

   always_comb begin
      if (bus_addr == ADDR_W'(SEL_LO))       sel = SEL_LO;
      else if (bus_addr == ADDR_W'(SEL_HI))  sel = SEL_HI;
      else if (bus_addr == ADDR_W'(SEL_CTL)) sel = SEL_CTL;
      else                                   sel = SEL_NONE;
   end

   assign rd_lo    = bus_rd && (sel == SEL_LO);
   assign rd_hi    = bus_rd && (sel == SEL_HI);
   assign wr_ctl   = bus_wr && (sel == SEL_CTL);
   assign go_req   = (wr_ctl && bus_wdata[CTL_START]) || (tmr_cmp_match && auto_en_q);
   assign flag_clr = irq_ack || (wr_ctl && bus_wdata[CTL_FLAG]);
   assign unused_wdata = ^bus_wdata[BYTE_W-1:CTL_FIELDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         auto_en_q  <= 1'b0;
         left_adj_q <= 1'b0;
      end else if (wr_ctl) begin
         auto_en_q  <= bus_wdata[CTL_AUTO];
         left_adj_q <= bus_wdata[CTL_LADJ];
      end
   end

   adcres_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .go_req      (go_req),
      .busy        (busy),
      .start_pulse (conv_start),
      .done        (done)
   );

   adcres_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .done      (done),
      .sample_in (conv_sample),
      .rd_lo     (rd_lo),
      .rd_hi     (rd_hi),
      .res_q     (res_q),
      .lock_q    (lock_q)
   );

   adcres_fmt #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) u_fmt (
      .sample   (res_q),
      .left_adj (left_adj_q),
      .lo_byte  (lo_byte),
      .hi_byte  (hi_byte)
   );

   adcres_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (done),
      .clr_i  (flag_clr),
      .flag_q (flag_q)
   );

   assign irq = flag_q;

   always_comb begin
      ctl_byte            = '0;
      ctl_byte[CTL_START] = busy;
      ctl_byte[CTL_AUTO]  = auto_en_q;
      ctl_byte[CTL_LADJ]  = left_adj_q;
      ctl_byte[CTL_FLAG]  = flag_q;
   end

   always_comb begin
      unique case (sel)
         SEL_LO:  bus_rdata = lo_byte;
         SEL_HI:  bus_rdata = hi_byte;
         SEL_CTL: bus_rdata = ctl_byte;
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/adcres_chk.sv
module adcres_chk #(
   parameter int unsigned SAMPLE_W    = 10,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned CONV_CYCLES = 13
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                done,
   input logic                lock_q,
   input logic                flag_q,
   input logic                left_adj_q,
   input logic [SAMPLE_W-1:0] res_q,
   input logic                conv_start,
   input logic                irq_ack,
   input logic                bus_rd,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [BYTE_W-1:0]   bus_rdata
);
   logic [15:0] dur_q;
   logic        rd_hi_c;

   assign rd_hi_c = bus_rd && (bus_addr == ADDR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) dur_q <= '0;
      else                 dur_q <= dur_q + 16'd1;
   end

   // R2
   conv_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (dur_q == 16'(CONV_CYCLES)));

   // R2
   start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $rose(busy));

   // R3
   busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> conv_start);

   // R4
   res_only_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(res_q) |-> $past(done));

   // R5
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !rd_hi_c) |=> $stable(res_q));

   // R7
   radj_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hi_c && !left_adj_q) |-> ((bus_rdata >> (SAMPLE_W - BYTE_W)) == '0));

   // R10
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> flag_q);

   // R11
   flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && !done) |=> !flag_q);
endmodule

bind adc_result_ctl adcres_chk #(
   .SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .lock_q     (lock_q),
   .flag_q     (flag_q),
   .left_adj_q (left_adj_q),
   .res_q      (res_q),
   .conv_start (conv_start),
   .irq_ack    (irq_ack),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata)
);

// File: tb/tb_adc_result_ctl.sv
`timescale 1ns/1ps
module tb_adc_result_ctl;
   localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       tmr_cmp_match = 1'b0;
   logic       conv_start;
   logic [9:0] conv_sample = '0;
   logic       irq;
   logic       irq_ack = 1'b0;

   int n_tests = 0, n_fail = 0;
   int starts_seen = 0, starts_exp = 0;
   bit finished = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   logic [9:0] cur_res;
   logic       cur_adj = 1'b0, cur_auto = 1'b0;

   always #5 clk = ~clk;

   adc_result_ctl dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tmr_cmp_match(tmr_cmp_match), .conv_start(conv_start),
      .conv_sample(conv_sample), .irq(irq), .irq_ack(irq_ack)
   );

   always @(posedge clk) if (rst_n && conv_start) starts_seen++;

   // Monitor: compares every read against the scoreboard queue
   always @(negedge clk) begin
      #1;
      if (rst_n && bus_rd) begin
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL unexpected read: actual %h expected none", bus_rdata);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_fail++;
               $display("FAIL %s addr %0d: actual %h expected %h", t, bus_addr, bus_rdata, e);
            end
         end
      end
   end

   function automatic logic [7:0] f_lo(input logic [9:0] s, input logic adj);
      return adj ? {s[1:0], 6'b0} : s[7:0];
   endfunction
   function automatic logic [7:0] f_hi(input logic [9:0] s, input logic adj);
      return adj ? s[9:2] : {6'b0, s[9:8]};
   endfunction
   function automatic logic [7:0] ctl(input logic fl, input logic adj,
                                      input logic au, input logic st);
      return {4'b0, fl, adj, au, st};
   endfunction

   task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", t, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tmr_cmp_match = 0; irq_ack = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = d;
      tmr_cmp_match = 0; irq_ack = 0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      bus_wr = 0; bus_rd = 1; bus_addr = a; tmr_cmp_match = 0; irq_ack = 0;
      exp_q.push_back(e);
      tag_q.push_back(t);
   endtask

   task automatic trig();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tmr_cmp_match = 1; irq_ack = 0;
   endtask

   task automatic ack();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; tmr_cmp_match = 0; irq_ack = 1;
   endtask

   // Start a conversion by CPU write; flag bit is left untouched
   task automatic launch(input logic [9:0] s);
      conv_sample = s;
      wr(A_CTL, ctl(1'b0, cur_adj, cur_auto, 1'b1));
      starts_exp++;
   endtask

   task automatic read_pair(input logic [9:0] s, input string t);
      rd(A_LO, f_lo(s, cur_adj), t);
      rd(A_HI, f_hi(s, cur_adj), t);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) idle();
      rst_n = 1'b1;
      idle();
      // R1 reset state
      check("R1 irq", {15'b0, irq}, 16'd0);
      check("R1 conv_start", {15'b0, conv_start}, 16'd0);
      rd(A_LO, 8'h00, "R1");
      rd(A_HI, 8'h00, "R1");
      rd(A_CTL, 8'h00, "R1");
      cur_res = 10'h000;

      // R2 R4 R7 R12: CPU start with flag clear in the same write
      conv_sample = 10'h2A5;
      wr(A_CTL, ctl(1'b1, 1'b0, 1'b0, 1'b1)); starts_exp++;   // edge E0
      repeat (4) idle();                                       // N1..N4
      read_pair(cur_res, "R4 old result during conversion");   // N5,N6
      repeat (6) idle();                                       // N7..N12
      rd(A_CTL, ctl(1'b0, 1'b0, 1'b0, 1'b1), "R2 busy in 13th cycle"); // N13
      rd(A_LO, f_lo(10'h2A5, 1'b0), "R12 result with irq");    // N14
      check("R12 irq high", {15'b0, irq}, 16'd1);
      rd(A_HI, f_hi(10'h2A5, 1'b0), "R7 high byte");
      rd(A_CTL, ctl(1'b1, 1'b0, 1'b0, 1'b0), "R2 start bit cleared");
      cur_res = 10'h2A5;
      idle();

      // R5: lock held across a completion drops the sample, R10 flag still sets
      wr(A_CTL, ctl(1'b1, 1'b0, 1'b0, 1'b0));
      rd(A_LO, f_lo(cur_res, 1'b0), "R5 lock read");
      launch(10'h15A);
      repeat (14) idle();
      check("R10 flag on dropped sample", {15'b0, irq}, 16'd1);
      rd(A_HI, f_hi(cur_res, 1'b0), "R5 dropped high");
      read_pair(cur_res, "R5 dropped pair");

      // R6: released lock lets the next completion through
      launch(10'h3C3);
      repeat (14) idle();
      cur_res = 10'h3C3;
      read_pair(cur_res, "R6 update after release");

      // R5: low read in the completion cycle blocks it
      launch(10'h0F0);
      repeat (12) idle();
      rd(A_LO, f_lo(cur_res, 1'b0), "R5 same-cycle low read");
      idle();
      rd(A_HI, f_hi(cur_res, 1'b0), "R5 same-cycle high");
      read_pair(cur_res, "R5 same-cycle pair");

      // R6: high read in the completion cycle releases and updates
      rd(A_LO, f_lo(cur_res, 1'b0), "R6 lock");
      launch(10'h1E7);
      repeat (12) idle();
      rd(A_HI, f_hi(cur_res, 1'b0), "R6 same-cycle high read");
      idle();
      cur_res = 10'h1E7;
      read_pair(cur_res, "R6 same-cycle update");

      // R8: left adjust applies to stored sample, then to a fresh one
      cur_adj = 1'b1;
      wr(A_CTL, ctl(1'b0, 1'b1, 1'b0, 1'b0));
      rd(A_HI, f_hi(cur_res, 1'b1), "R8 left high stored");
      rd(A_LO, f_lo(cur_res, 1'b1), "R8 left low stored");
      rd(A_HI, f_hi(cur_res, 1'b1), "R8 left high again");
      launch(10'h36B);
      repeat (14) idle();
      cur_res = 10'h36B;
      read_pair(cur_res, "R8 left new sample");
      cur_adj = 1'b0;
      wr(A_CTL, ctl(1'b1, 1'b0, 1'b0, 1'b0));
      read_pair(cur_res, "R7 back to right");

      // R9: trigger with auto disabled has no effect
      trig();
      idle();
      rd(A_CTL, ctl(1'b0, 1'b0, 1'b0, 1'b0), "R9 trigger ignored when disabled");
      check("R9 no strobe", 16'(starts_seen), 16'(starts_exp));

      // R9 R3: auto trigger, retrigger and start write while busy ignored
      cur_auto = 1'b1;
      wr(A_CTL, ctl(1'b1, 1'b0, 1'b1, 1'b0));
      conv_sample = 10'h2D4;
      trig(); starts_exp++;                                    // M0
      repeat (4) idle();                                       // M1..M4
      trig();                                                  // M5 ignored
      wr(A_CTL, ctl(1'b0, 1'b0, 1'b1, 1'b1));                  // M6 ignored
      repeat (6) idle();                                       // M7..M12
      rd(A_CTL, ctl(1'b0, 1'b0, 1'b1, 1'b1), "R3 busy until original end");
      rd(A_CTL, ctl(1'b1, 1'b0, 1'b1, 1'b0), "R3 R9 done on time");
      cur_res = 10'h2D4;
      read_pair(cur_res, "R9 auto result");
      check("R3 one strobe per conversion", 16'(starts_seen), 16'(starts_exp));

      // R11: acknowledge clears
      ack();
      idle();
      check("R11 ack clears", {15'b0, irq}, 16'd0);
      // R11: write-one clears
      launch(10'h011);
      repeat (14) idle();
      cur_res = 10'h011;
      check("R10 flag set", {15'b0, irq}, 16'd1);
      wr(A_CTL, ctl(1'b1, 1'b0, 1'b1, 1'b0));
      idle();
      check("R11 write-one clears", {15'b0, irq}, 16'd0);
      // R11: set wins over ack in the completion cycle
      launch(10'h3FF);
      repeat (12) idle();
      ack();
      idle();
      cur_res = 10'h3FF;
      check("R11 set wins over clear", {15'b0, irq}, 16'd1);
      read_pair(cur_res, "R7 full-scale sample");
      idle();
      check("R2 strobe count", 16'(starts_seen), 16'(starts_exp));
      check("scoreboard drained", 16'(exp_q.size()), 16'd0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule